// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs single read and write cycles on one channel of an external memory or peripheral bus. An internal agent raises a level request along with the direction, the address and any write data. It holds the request until a one-cycle acknowledge comes back. On the external side the block drives the address, the write data with its drive enable, and three active-low controls: chip-enable, write strobe and read strobe. It also samples an external data bus and a ready input. Every external output comes from a register.

A small control register sets how the channel behaves. It holds four fields:
- a 2-bit rate code that sets the divider;
- a 3-bit gap count;
- a ready-mode bit;
- a channel-enable bit.

The external bus rate is not a second clock. A clock-enable divider on the internal clock gives one tick per external period, and every phase boundary falls on a tick. The cycle runs through these phases in order:
1. address setup;
2. chip-enable setup;
3. strobe;
4. strobe release with chip-enable still held;
5. chip-enable release with the address still held.

Each setup or hold phase lasts the gap count plus one external period. The strobe lasts one period, or longer while ready mode holds it for the ready input. A request to a disabled channel gets an error acknowledge straight away and causes no activity on the pins.

The state machine has these states:
- ST_IDLE
- ST_ADDR
- ST_CE_SETUP
- ST_STROBE
- ST_STB_HOLD
- ST_CE_HOLD
- ST_DONE
- ST_ERR

It has these transitions:
- The request is accepted on a tick: ST_IDLE to ST_ADDR.
- A request arrives while the channel is disabled: ST_IDLE to ST_ERR.
- The address setup ends: ST_ADDR to ST_CE_SETUP.
- The chip-enable setup ends: ST_CE_SETUP to ST_STROBE.
- The strobe ends: ST_STROBE to ST_STB_HOLD. This happens on a tick, and in ready mode only with ready seen high.
- The strobe hold ends: ST_STB_HOLD to ST_CE_HOLD.
- The chip-enable hold ends: ST_CE_HOLD to ST_DONE.
- The acknowledge is issued: ST_DONE to ST_IDLE and ST_ERR to ST_IDLE.

Top module: `ebus_seq`

## Requirements
- R1: The rate code sets the length P of the external period in internal clocks: code 0 gives P=4, code 1 gives P=3, code 2 gives P=2 and code 3 gives P=1. All edges of the address, chip-enable, strobe and acknowledge outputs fall a whole number of periods apart.
- R2: With gap code W (0 to 7), chip-enable goes low (W+1)*P clocks after the new address appears. The strobe goes low (W+1)*P clocks after chip-enable goes low. A strobe is only ever low while chip-enable is low.
- R3: The release mirrors the setup. Chip-enable goes high (W+1)*P clocks after the strobe goes high. The acknowledge is high (W+1)*P clocks after chip-enable goes high, and the address does not change while chip-enable is low.
- R4: With ready mode off, the strobe stays low for exactly P clocks, and the ready input has no effect even when it is held low.
- R5: With ready mode on, the strobe stays low while ready is low, for any number of clocks. Once ready rises, the strobe goes high between 2 and P+1 clocks later.
- R6: A request to a disabled channel (enable bit 0) is answered in the next clock with the acknowledge and the error flag both high. Chip-enable, both strobes and the data drive enable stay inactive.
- R7: After reset all external controls are inactive: chip-enable, write strobe and read strobe are all high, the data drive enable is low, and the acknowledge is low. Without strap loading, every control field is 0, so the channel is disabled.
- R8: With strap loading enabled (parameter STRAP_LOAD=1), the rate code and the enable bit take the strap inputs during reset.
- R9: A write cycle uses only the write strobe; the read strobe stays high. The data drive enable is high and the data output carries the request data from the address phase until the strobe is released.
- R10: A read cycle uses only the read strobe; the write strobe stays high and the drive enable stays low. The data bus value present in the last internal clock of the strobe phase is returned on ack_rdata.
- R11: The acknowledge of a completed cycle is high for one clock, with the error flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_speed | input | 2 | Rate code loaded at reset when STRAP_LOAD=1 |
| strap_enable | input | 1 | Enable bit loaded at reset when STRAP_LOAD=1 |
| cfg_we | input | 1 | Writes the control fields below |
| cfg_speed | input | 2 | Rate code to write |
| cfg_wait | input | 3 | Gap code to write |
| cfg_rdy_mode | input | 1 | Ready mode to write |
| cfg_enable | input | 1 | Channel enable to write |
| req | input | 1 | Cycle request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-clock completion pulse |
| ack_err | output | 1 | Request was refused (channel disabled) |
| ack_rdata | output | DATA_W | Read data of the last read |
| ext_addr | output | ADDR_W | External address |
| ext_dout | output | DATA_W | External write data |
| ext_doe | output | 1 | Drive enable for ext_dout |
| ext_din | input | DATA_W | External read data |
| ext_ce_n | output | 1 | Chip-enable, active low |
| ext_we_n | output | 1 | Write strobe, active low |
| ext_oe_n | output | 1 | Read strobe, active low |
| ext_rdy | input | 1 | External ready, used in ready mode |

## Verification
The hardest situation to reach is a ready stall of arbitrary length. It must be followed by a release whose timing depends on where the free-running divider happens to be.

The stimulus holds ready low from before the request, waits a chosen number of clocks after the strobe falls, and confirms that the strobe is still low. It then raises ready at once and measures the delay to release against the 2 to P+1 clock window at each rate.

Exact gap spacing is reached by sweeping every rate code against every gap code. Each sweep step measures the clock distance between successive pin edges. During reads the data bus is driven with the wanted value only while the read strobe is low, so a capture at the wrong clock returns the wrong data.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int SPEED_W = 2;
    localparam int WAIT_W  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CE_SETUP,
        ST_STROBE,
        ST_STB_HOLD,
        ST_CE_HOLD,
        ST_DONE,
        ST_ERR
    } ebus_state_e;

    typedef struct packed {
        logic               rdy_mode;
        logic [SPEED_W-1:0] speed;
        logic               enable;
        logic [WAIT_W-1:0]  waits;
    } ebus_ctl_t;

endpackage

// File: rtl/ebus_ctl_reg.sv
module ebus_ctl_reg
    import ebus_pkg::*;
#(
    parameter bit STRAP_LOAD = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] strap_speed,
    input  logic               strap_enable,
    input  logic               cfg_we,
    input  ebus_ctl_t          cfg_ctl,
    output ebus_ctl_t          ctl_q
);

    ebus_ctl_t rst_val;

    generate
        if (STRAP_LOAD) begin : g_strap
            always_comb begin
                rst_val        = '0;
                rst_val.speed  = strap_speed;
                rst_val.enable = strap_enable;
            end
        end else begin : g_zero
            logic unused_straps;
            assign unused_straps = ^{strap_speed, strap_enable};
            assign rst_val = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= rst_val;
        end else if (cfg_we) begin
            ctl_q <= cfg_ctl;
        end
    end

endmodule

// File: rtl/ebus_tick_gen.sv
module ebus_tick_gen #(
    parameter int SPEED_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] speed,
    output logic               tick
);

    localparam int DIV_W = SPEED_W;
    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'((2 ** SPEED_W) - 1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_m1;

    // Highest rate code divides by one, lowest by 2**SPEED_W.
    assign div_m1 = DIV_TOP - speed;
    assign tick   = (cnt_q >= div_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ebus_phase_timer.sv
module ebus_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Saturates at the limit so a stalled phase keeps reporting done on ticks.
    assign done = tick && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ebus_cycle_fsm.sv
module ebus_cycle_fsm
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              phase_done,
    output logic              phase_clr,
    output logic [WAIT_W-1:0] phase_limit,
    input  logic              ch_enable,
    input  logic              ch_rdy_mode,
    input  logic [WAIT_W-1:0] ch_waits,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic              ack_err,
    output logic [DATA_W-1:0] ack_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dout,
    output logic              ext_doe,
    input  logic [DATA_W-1:0] ext_din,
    output logic              ext_ce_n,
    output logic              ext_we_n,
    output logic              ext_oe_n,
    input  logic              ext_rdy
);

    ebus_state_e       state_q, state_d;
    logic              we_q;
    logic              rdy_mode_q;
    logic [WAIT_W-1:0] waits_q;
    logic              rdy_q;
    logic              accept;
    logic              we_d;
    logic              strobe_end;

    assign accept     = (state_q == ST_IDLE) && (state_d == ST_ADDR);
    assign we_d       = accept ? req_we : we_q;
    assign strobe_end = (state_q == ST_STROBE) && (state_d == ST_STB_HOLD);

    assign phase_clr   = (state_d != state_q);
    assign phase_limit = (state_q == ST_STROBE) ? '0 : waits_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req && !ch_enable) begin
                    state_d = ST_ERR;
                end else if (req && tick) begin
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (phase_done) state_d = ST_CE_SETUP;
            end
            ST_CE_SETUP: begin
                if (phase_done) state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (phase_done && (!rdy_mode_q || rdy_q)) state_d = ST_STB_HOLD;
            end
            ST_STB_HOLD: begin
                if (phase_done) state_d = ST_CE_HOLD;
            end
            ST_CE_HOLD: begin
                if (phase_done) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            ST_ERR:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and per-cycle latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            we_q       <= 1'b0;
            rdy_mode_q <= 1'b0;
            waits_q    <= '0;
            rdy_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            rdy_q   <= ext_rdy;
            if (accept) begin
                we_q       <= req_we;
                rdy_mode_q <= ch_rdy_mode;
                waits_q    <= ch_waits;
            end
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack       <= 1'b0;
            ack_err   <= 1'b0;
            ack_rdata <= '0;
            ext_addr  <= '0;
            ext_dout  <= '0;
            ext_doe   <= 1'b0;
            ext_ce_n  <= 1'b1;
            ext_we_n  <= 1'b1;
            ext_oe_n  <= 1'b1;
        end else begin
            ack      <= (state_d == ST_DONE) || (state_d == ST_ERR);
            ack_err  <= (state_d == ST_ERR);
            ext_ce_n <= !((state_d == ST_CE_SETUP) || (state_d == ST_STROBE) ||
                          (state_d == ST_STB_HOLD));
            ext_we_n <= !((state_d == ST_STROBE) && we_d);
            ext_oe_n <= !((state_d == ST_STROBE) && !we_d);
            ext_doe  <= we_d && ((state_d == ST_ADDR) || (state_d == ST_CE_SETUP) ||
                                 (state_d == ST_STROBE));
            if (accept) begin
                ext_addr <= req_addr;
                ext_dout <= req_wdata;
            end
            if (strobe_end && !we_q) begin
                ack_rdata <= ext_din;
            end
        end
    end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter bit STRAP_LOAD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_speed,
    input  logic              strap_enable,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_speed,
    input  logic [2:0]        cfg_wait,
    input  logic              cfg_rdy_mode,
    input  logic              cfg_enable,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic              ack_err,
    output logic [DATA_W-1:0] ack_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dout,
    output logic              ext_doe,
    input  logic [DATA_W-1:0] ext_din,
    output logic              ext_ce_n,
    output logic              ext_we_n,
    output logic              ext_oe_n,
    input  logic              ext_rdy
);

    ebus_ctl_t         cfg_ctl;
    ebus_ctl_t         ctl_q;
    logic              tick;
    logic              phase_done;
    logic              phase_clr;
    logic [WAIT_W-1:0] phase_limit;

    always_comb begin
        cfg_ctl.rdy_mode = cfg_rdy_mode;
        cfg_ctl.speed    = cfg_speed;
        cfg_ctl.enable   = cfg_enable;
        cfg_ctl.waits    = cfg_wait;
    end

    ebus_ctl_reg #(.STRAP_LOAD(STRAP_LOAD)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_speed  (strap_speed),
        .strap_enable (strap_enable),
        .cfg_we       (cfg_we),
        .cfg_ctl      (cfg_ctl),
        .ctl_q        (ctl_q)
    );

    ebus_tick_gen #(.SPEED_W(SPEED_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .speed (ctl_q.speed),
        .tick  (tick)
    );

    ebus_phase_timer #(.CNT_W(WAIT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_clr),
        .tick  (tick),
        .limit (phase_limit),
        .done  (phase_done)
    );

    ebus_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .phase_done  (phase_done),
        .phase_clr   (phase_clr),
        .phase_limit (phase_limit),
        .ch_enable   (ctl_q.enable),
        .ch_rdy_mode (ctl_q.rdy_mode),
        .ch_waits    (ctl_q.waits),
        .req         (req),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .ack         (ack),
        .ack_err     (ack_err),
        .ack_rdata   (ack_rdata),
        .ext_addr    (ext_addr),
        .ext_dout    (ext_dout),
        .ext_doe     (ext_doe),
        .ext_din     (ext_din),
        .ext_ce_n    (ext_ce_n),
        .ext_we_n    (ext_we_n),
        .ext_oe_n    (ext_oe_n),
        .ext_rdy     (ext_rdy)
    );

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              ack_err,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [DATA_W-1:0] ext_dout,
    input logic              ext_doe,
    input logic              ext_ce_n,
    input logic              ext_we_n,
    input logic              ext_oe_n
);

    a_r2_strobe_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_we_n || !ext_oe_n) |-> !ext_ce_n);

    a_r3_addr_held_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_ce_n && $past(!ext_ce_n)) |-> $stable(ext_addr));

    a_r6_refusal_quiet_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> (ext_ce_n && ext_we_n && ext_oe_n && !ext_doe));

    a_r9_drive_during_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_we_n |-> (ext_doe && $stable(ext_dout)));

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_we_n && !ext_oe_n));

    a_r10_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_oe_n |-> !ext_doe);

    a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r11_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> ack);

endmodule

bind ebus_seq ebus_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .ack_err  (ack_err),
    .ext_addr (ext_addr),
    .ext_dout (ext_dout),
    .ext_doe  (ext_doe),
    .ext_ce_n (ext_ce_n),
    .ext_we_n (ext_we_n),
    .ext_oe_n (ext_oe_n)
);

// File: tb/ebus_seq_test.sv
`timescale 1ns/1ps
module ebus_seq_test;

    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    strap_speed;
    logic          strap_enable;
    logic          cfg_we;
    logic [1:0]    cfg_speed;
    logic [2:0]    cfg_wait;
    logic          cfg_rdy_mode;
    logic          cfg_enable;
    logic          req;
    logic          req_we;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          ack;
    logic          ack_err;
    logic [DW-1:0] ack_rdata;
    logic [AW-1:0] ext_addr;
    logic [DW-1:0] ext_dout;
    logic          ext_doe;
    logic [DW-1:0] ext_din;
    logic          ext_ce_n;
    logic          ext_we_n;
    logic          ext_oe_n;
    logic          ext_rdy;

    int n_tests = 0;
    int n_fail  = 0;
    logic [AW-1:0] next_addr = 16'h0100;

    ebus_seq #(.ADDR_W(AW), .DATA_W(DW), .STRAP_LOAD(1'b1)) uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] spd, input logic en);
        rst_n = 1'b0; strap_speed = spd; strap_enable = en;
        cfg_we = 0; cfg_speed = 0; cfg_wait = 0; cfg_rdy_mode = 0; cfg_enable = 0;
        req = 0; req_we = 0; req_addr = 0; req_wdata = 0; ext_din = 0; ext_rdy = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic configure(input int spd, input int w, input bit rm, input bit en);
        @(negedge clk);
        cfg_we = 1; cfg_speed = 2'(spd); cfg_wait = 3'(w); cfg_rdy_mode = rm; cfg_enable = en;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Runs one enabled cycle and checks all edge spacings.
    // stall = 0: ready mode off, ext_rdy held low. stall > 0: ready raised
    // stall clocks after the strobe falls.
    task automatic run_cycle(input bit we, input int p, input int w, input int stall);
        int cyc = 0;
        int t_a = -1, t_ce = -1, t_s = -1, t_sr = -1, t_cr = -1, t_ack = -1, t_r = -1;
        bit other_bad = 0, drive_bad = 0, stb_low;
        logic [AW-1:0] a = next_addr;
        logic [DW-1:0] wd = a ^ 16'h5A3C;
        logic [DW-1:0] rd = a ^ 16'hC3A5;
        int g = (w + 1) * p;
        next_addr = next_addr + 16'h0011;
        ext_rdy = 0;
        req = 1; req_we = we; req_addr = a; req_wdata = wd;
        while (t_ack < 0 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            stb_low = we ? !ext_we_n : !ext_oe_n;
            ext_din = ext_oe_n ? ~rd : rd;
            if (t_a < 0 && ext_addr == a) t_a = cyc;
            if (t_ce < 0 && !ext_ce_n) t_ce = cyc;
            if (t_s < 0 && stb_low) t_s = cyc;
            if (t_s >= 0 && t_sr < 0 && !stb_low) t_sr = cyc;
            if (t_ce >= 0 && t_cr < 0 && ext_ce_n) t_cr = cyc;
            if (ack) t_ack = cyc;
            if (we ? !ext_oe_n : !ext_we_n) other_bad = 1;
            if (we && t_a >= 0 && t_sr < 0 && !(ext_doe && ext_dout == wd)) drive_bad = 1;
            if (!we && ext_doe) drive_bad = 1;
            if (stall > 0 && t_s >= 0 && t_r < 0 && cyc - t_s == stall) begin
                chk(stb_low, "R5 strobe held while ready low", int'(stb_low), 1);
                ext_rdy = 1;
                t_r = cyc;
            end
        end
        req = 0;
        chk(t_ack > 0, "R11 cycle completes", t_ack, 1);
        chk(t_ce - t_a == g, "R2 addr to ce spacing", t_ce - t_a, g);
        chk(t_s - t_ce == g, "R2 ce to strobe spacing", t_s - t_ce, g);
        if (stall == 0)
            chk(t_sr - t_s == p, "R4 strobe width, ready ignored", t_sr - t_s, p);
        else begin
            chk(t_sr - t_s >= stall, "R5 stall length", t_sr - t_s, stall);
            chk(t_sr - t_r >= 2 && t_sr - t_r <= p + 1, "R5 release after ready",
                t_sr - t_r, p + 1);
        end
        chk(t_cr - t_sr == g, "R3 strobe release to ce release", t_cr - t_sr, g);
        chk(t_ack - t_cr == g, "R3 ce release to ack", t_ack - t_cr, g);
        chk((t_ce - t_a) % p == 0, "R1 edges on period grid", (t_ce - t_a) % p, 0);
        chk(!ack_err, "R11 no error on enabled cycle", int'(ack_err), 0);
        chk(!other_bad, "R9 R10 unused strobe stays high", int'(other_bad), 0);
        chk(!drive_bad, we ? "R9 write data drive" : "R10 no drive on read",
            int'(drive_bad), 0);
        if (!we) chk(ack_rdata == rd, "R10 read data captured", int'(ack_rdata), int'(rd));
        @(negedge clk);
        chk(!ack, "R11 ack lasts one clock", int'(ack), 0);
        ext_rdy = 0;
    endtask

    task automatic test_reset();
        do_reset(2'b00, 1'b0);
        chk(ext_ce_n && ext_we_n && ext_oe_n, "R7 controls inactive",
            int'({ext_ce_n, ext_we_n, ext_oe_n}), 7);
        chk(!ext_doe && !ack, "R7 drive and ack low", int'({ext_doe, ack}), 0);
        // Fields reset to 0: channel disabled, so a request is refused.
        req = 1; req_we = 1; req_addr = 16'h0042;
        @(negedge clk);
        chk(ack && ack_err, "R7 disabled after reset", int'({ack, ack_err}), 3);
        req = 0;
        @(negedge clk);
    endtask

    task automatic test_disabled();
        configure(3, 2, 0, 0);
        req = 1; req_we = 1; req_addr = 16'h0777; req_wdata = 16'h1234;
        @(negedge clk);
        chk(ack && ack_err, "R6 immediate error ack", int'({ack, ack_err}), 3);
        chk(ext_ce_n && ext_we_n && ext_oe_n && !ext_doe, "R6 no pin activity",
            int'({ext_ce_n, ext_we_n, ext_oe_n, ext_doe}), 14);
        req = 0;
        @(negedge clk);
        chk(!ack && ext_ce_n, "R6 ack drops, pins idle", int'({ack, ext_ce_n}), 1);
    endtask

    task automatic test_straps();
        do_reset(2'b11, 1'b1);
        run_cycle(1'b1, 1, 0, 0);   // R8: full rate and enabled with no write
        do_reset(2'b01, 1'b1);
        run_cycle(1'b0, 3, 0, 0);   // R8: rate code 1 taken from straps
    endtask

    task automatic test_sweep();
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 8; w++) begin
                configure(s, w, 0, 1);
                run_cycle(w[0], 4 - s, w, 0);   // R1 R2 R3 every rate and gap
            end
        end
    endtask

    task automatic test_ready();
        for (int s = 0; s < 4; s++) begin
            configure(s, 1, 1, 1);
            run_cycle(1'b0, 4 - s, 1, 7 + 5 * s);   // R5 read stall
            run_cycle(1'b1, 4 - s, 1, 23);          // R5 write stall
        end
        configure(1, 0, 1, 1);
        run_cycle(1'b0, 3, 0, 61);
    endtask

    initial begin
        test_reset();
        test_disabled();
        configure(2, 3, 0, 1);
        run_cycle(1'b1, 2, 3, 0);   // R9 write at half rate
        run_cycle(1'b0, 2, 3, 0);   // R10 read at half rate
        test_sweep();
        test_ready();
        test_straps();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule